// File: doc/BRIEF.md
# FIFO Threshold Interrupt Status Unit

This block sits between the register port of an I2C controller and its bit engine. It holds one byte FIFO for transmit data and one for receive data, keeps two counters of the bytes still outstanding in the current transfer, and raises four data-request flags: transmit-ready, transmit-drain, receive-ready and receive-drain. The ready flags fire when a FIFO crosses its programmed threshold. The drain flags fire when the bytes left in the transfer can no longer reach the threshold, so software is still called to service the tail of the transfer.

The flags sit in a status register whose bits are cleared by writing 1. An enable register masks them onto a single interrupt line. Software reaches everything through a 16-bit register port with a 3-bit address. The bit engine pulls transmit bytes and puts receive bytes through a simple strobe interface. A transfer length written to the count register reloads both outstanding counters.

Each direction has a phase tracker with four states. IDLE is left only on a count load. BULK means the outstanding count is at or above the threshold. TAIL means the count is non-zero but below the threshold. END means the count is zero and stays so until the next load. A load from any state, or a decrement or a threshold change in BULK, TAIL or END, reclassifies the count on the next clock edge.

Top module: `i2c_fifo_irq_unit`

## Requirements
- R1: After reset the status, enable, threshold-control and count registers read 0, both FIFO levels read 0, and irq is low.
- R2: The control register at address 3 holds the transmit threshold minus one in bits [5:0] and the receive threshold minus one in bits [13:8]. These fields read back as written, so a written 0 means a threshold of 1.
- R3: Status bit 0 (receive-ready) is set while the receive FIFO level is at or above the receive threshold.
- R4: Status bit 1 (receive-drain) is set once a loaded transfer has received all its bytes and the receive FIFO holds between 1 and threshold-1 bytes.
- R5: Status bit 2 (transmit-ready) is set while the transmit FIFO level is below the transmit threshold and the bytes still to be written by software are at least the threshold.
- R6: Status bit 3 (transmit-drain) is set while the transmit FIFO level is below the transmit threshold and the bytes still to be written are between 1 and threshold-1.
- R7: For each direction, the ready flag is never set at the same time as the drain flag. When drain is raised, a pending ready flag is cleared.
- R8: Status flags stay set after their condition goes away. Writing 1 to a bit at address 1 clears it, unless its condition still holds, in which case it stays set.
- R9: irq is high exactly when some status bit is set whose bit in the enable register (address 2, bits [3:0]) is also set.
- R10: Writing 1 to bit 6 or to bit 14 of the control register empties the transmit or the receive FIFO. These bits read back as 0, and the write does not change the threshold fields.
- R11: A write to address 0 pushes bits [7:0] into the transmit FIFO, and a read of address 0 pops the receive FIFO into bits [7:0]. Both FIFOs are first in, first out. A push into a full FIFO is ignored, and a pop from an empty one returns 0. Address 5 reads the receive level in bits [15:8] and the transmit level in bits [7:0].
- R12: Address 6 reads the FIFO depth code n in bits [3:0], where the depth is 8 << n bytes.
- R13: A write to address 4 loads the transfer length into both outstanding counters. Each accepted software push decrements the transmit counter, and each accepted engine byte decrements the receive counter. Neither counter goes below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive FIFO at address 0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Masked interrupt request |
| eng_tx_take | input | 1 | Bit engine takes one transmit byte |
| eng_tx_byte | output | 8 | Head of the transmit FIFO (0 when empty) |
| eng_tx_empty | output | 1 | Transmit FIFO empty |
| eng_rx_put | input | 1 | Bit engine delivers one receive byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_full | output | 1 | Receive FIFO full |

## Verification
The bench goes after the moment a transfer's tail drops below the threshold. A design that compares with the wrong bound would raise ready for the last few bytes or stay silent, and the transfer would hang. It drives a receive-drain while a stale receive-ready is pending, which catches a design that lets both flags stand. It clears a flag whose condition still holds, which exposes a clear that wins over the set. It also pushes into a full FIFO and pops an empty one, and it flushes while thresholds are programmed, which catches lost data ordering and flush bits that corrupt the threshold fields. A seeded random mix of pushes, pulls, reloads, threshold changes and flushes is compared against a bench model of the four flag conditions after every step.

// File: rtl/i2c_fifo_irq_pkg.sv
package i2c_fifo_irq_pkg;

    localparam int ADDR_W = 3;
    localparam int REG_W  = 16;
    localparam int THR_W  = 6;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_DATA   = 3'd0,
        ADDR_STAT   = 3'd1,
        ADDR_IRQEN  = 3'd2,
        ADDR_BUFCTL = 3'd3,
        ADDR_COUNT  = 3'd4,
        ADDR_LEVEL  = 3'd5,
        ADDR_DEPTH  = 3'd6,
        ADDR_RSVD   = 3'd7
    } reg_addr_e;

    localparam int NFLAGS     = 4;
    localparam int FLG_RX_RDY = 0;
    localparam int FLG_RX_DRN = 1;
    localparam int FLG_TX_RDY = 2;
    localparam int FLG_TX_DRN = 3;

    localparam int TXTH_LSB = 0;
    localparam int TXFL_BIT = 6;
    localparam int RXTH_LSB = 8;
    localparam int RXFL_BIT = 14;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BULK = 2'd1,
        PH_TAIL = 2'd2,
        PH_END  = 2'd3
    } phase_e;

endpackage

// File: rtl/fifo_byte_store.sv
module fifo_byte_store #(
    parameter int AW = 4,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [AW:0]   level,
    output logic          full,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;
    logic          do_push;
    logic          do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign level   = cnt;
    assign rdata   = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    // R11: a push into a full FIFO leaves it full with no growth
    assert_fifo_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (level == (AW+1)'(DEPTH)));

    // R11: a pop from an empty FIFO leaves it empty
    assert_fifo_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/xfer_phase_tracker.sv
module xfer_phase_tracker
    import i2c_fifo_irq_pkg::*;
#(
    parameter int CW = 16,
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    input  logic          dec,
    input  logic [TW:0]   thr,
    output phase_e        phase,
    output logic [CW-1:0] left
);
    localparam int XW = (CW > TW + 1) ? CW : TW + 1;

    phase_e        ph_q;
    phase_e        ph_nx;
    logic [CW-1:0] left_q;
    logic [CW-1:0] left_nx;

    function automatic phase_e classify(input logic [CW-1:0] n, input logic [TW:0] t);
        if (n == '0)                  return PH_END;
        else if (XW'(n) < XW'(t))     return PH_TAIL;
        else                          return PH_BULK;
    endfunction

    always_comb begin
        left_nx = left_q;
        if (load)                        left_nx = len;
        else if (dec && left_q != '0)    left_nx = left_q - 1'b1;
    end

    always_comb begin
        ph_nx = ph_q;
        unique case (ph_q)
            PH_IDLE: if (load) ph_nx = classify(left_nx, thr);
            PH_BULK: ph_nx = classify(left_nx, thr);
            PH_TAIL: ph_nx = classify(left_nx, thr);
            PH_END:  ph_nx = classify(left_nx, thr);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            left_q <= '0;
        end else begin
            ph_q   <= ph_nx;
            left_q <= left_nx;
        end
    end

    always_comb begin
        phase = ph_q;
        left  = left_q;
    end

    // R13: a finished transfer stays finished until the next length load
    assert_end_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_END && !load) |=> (phase == PH_END));

    // R13: no phase is entered before a length has been loaded
    assert_idle_until_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !load) |=> (phase == PH_IDLE));

endmodule

// File: rtl/flag_status_bank.sv
module flag_status_bank
    import i2c_fifo_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set,
    input  logic              clr_we,
    input  logic [NFLAGS-1:0] clr_mask,
    input  logic              en_we,
    input  logic [NFLAGS-1:0] en_wdata,
    output logic [NFLAGS-1:0] flags,
    output logic [NFLAGS-1:0] en,
    output logic              irq
);
    logic [NFLAGS-1:0] flg_q;
    logic [NFLAGS-1:0] flg_nx;
    logic [NFLAGS-1:0] en_q;

    always_comb begin
        flg_nx = (flg_q & ~(clr_we ? clr_mask : '0)) | set;
        if (flg_nx[FLG_RX_DRN]) flg_nx[FLG_RX_RDY] = 1'b0;
        if (flg_nx[FLG_TX_DRN]) flg_nx[FLG_TX_RDY] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
            en_q  <= '0;
        end else begin
            flg_q <= flg_nx;
            if (en_we) en_q <= en_wdata;
        end
    end

    assign flags = flg_q;
    assign en    = en_q;
    assign irq   = |(flg_q & en_q);

    // R7: ready and drain never coexist in one direction
    assert_rx_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[FLG_RX_RDY] && flags[FLG_RX_DRN]));
    assert_tx_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags[FLG_TX_RDY] && flags[FLG_TX_DRN]));

    // R7: a drain request removes a pending ready request
    assert_rx_drain_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set[FLG_RX_DRN] |=> !flags[FLG_RX_RDY]);

    for (genvar i = 0; i < NFLAGS; i++) begin : g_w1c
        // R8: a write-one clear takes effect when the condition is absent
        assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_mask[i] && !set[i]) |=> !flags[i]);
    end

endmodule

// File: rtl/i2c_fifo_irq_unit.sv
module i2c_fifo_irq_unit
    import i2c_fifo_irq_pkg::*;
#(
    parameter int FIFO_AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq,
    input  logic        eng_tx_take,
    output logic [7:0]  eng_tx_byte,
    output logic        eng_tx_empty,
    input  logic        eng_rx_put,
    input  logic [7:0]  eng_rx_byte,
    output logic        eng_rx_full
);
    localparam int LW   = FIFO_AW + 1;
    localparam int CMPW = (LW > THR_W + 1) ? LW : THR_W + 1;

    reg_addr_e         addr;
    logic [THR_W-1:0]  tx_thm1;
    logic [THR_W-1:0]  rx_thm1;
    logic [THR_W:0]    tx_thr;
    logic [THR_W:0]    rx_thr;
    logic [REG_W-1:0]  count_q;
    logic              wr_data, rd_data, wr_stat, wr_en, wr_ctl, wr_cnt;
    logic              tx_flush, rx_flush;
    logic [7:0]        rx_head;
    logic [LW-1:0]     tx_lvl, rx_lvl;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    phase_e            tx_ph, rx_ph;
    logic [REG_W-1:0]  tx_left, rx_left;
    logic [NFLAGS-1:0] cond;
    logic [NFLAGS-1:0] flags, en;
    logic [REG_W-1:0]  unused_lefts;
    logic              unused_ctl;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_data = reg_we && addr == ADDR_DATA;
    assign rd_data = reg_re && addr == ADDR_DATA;
    assign wr_stat = reg_we && addr == ADDR_STAT;
    assign wr_en   = reg_we && addr == ADDR_IRQEN;
    assign wr_ctl  = reg_we && addr == ADDR_BUFCTL;
    assign wr_cnt  = reg_we && addr == ADDR_COUNT;

    assign tx_flush = wr_ctl && reg_wdata[TXFL_BIT];
    assign rx_flush = wr_ctl && reg_wdata[RXFL_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thm1 <= '0;
            rx_thm1 <= '0;
            count_q <= '0;
        end else begin
            if (wr_ctl) begin
                tx_thm1 <= reg_wdata[TXTH_LSB +: THR_W];
                rx_thm1 <= reg_wdata[RXTH_LSB +: THR_W];
            end
            if (wr_cnt) count_q <= reg_wdata;
        end
    end

    assign tx_thr = {1'b0, tx_thm1} + 1'b1;
    assign rx_thr = {1'b0, rx_thm1} + 1'b1;

    fifo_byte_store #(.AW(FIFO_AW), .W(8)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(wr_data), .wdata(reg_wdata[7:0]),
        .pop(eng_tx_take), .rdata(eng_tx_byte),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    fifo_byte_store #(.AW(FIFO_AW), .W(8)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(eng_rx_put), .wdata(eng_rx_byte),
        .pop(rd_data), .rdata(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    assign eng_tx_empty = tx_empty;
    assign eng_rx_full  = rx_full;

    xfer_phase_tracker #(.CW(REG_W), .TW(THR_W)) u_tx_track (
        .clk(clk), .rst_n(rst_n), .load(wr_cnt), .len(reg_wdata),
        .dec(wr_data && !tx_full && !tx_flush), .thr(tx_thr),
        .phase(tx_ph), .left(tx_left)
    );

    xfer_phase_tracker #(.CW(REG_W), .TW(THR_W)) u_rx_track (
        .clk(clk), .rst_n(rst_n), .load(wr_cnt), .len(reg_wdata),
        .dec(eng_rx_put && !rx_full && !rx_flush), .thr(rx_thr),
        .phase(rx_ph), .left(rx_left)
    );

    assign unused_lefts = tx_left ^ rx_left;
    assign unused_ctl   = rx_empty ^ reg_wdata[15] ^ reg_wdata[7];

    always_comb begin
        cond = '0;
        cond[FLG_TX_RDY] = (tx_ph == PH_BULK) && (CMPW'(tx_lvl) < CMPW'(tx_thr));
        cond[FLG_TX_DRN] = (tx_ph == PH_TAIL) && (CMPW'(tx_lvl) < CMPW'(tx_thr));
        cond[FLG_RX_DRN] = (rx_ph == PH_END) && (rx_lvl != '0)
                           && (CMPW'(rx_lvl) < CMPW'(rx_thr));
        cond[FLG_RX_RDY] = (CMPW'(rx_lvl) >= CMPW'(rx_thr));
    end

    flag_status_bank u_flags (
        .clk(clk), .rst_n(rst_n), .set(cond),
        .clr_we(wr_stat), .clr_mask(reg_wdata[NFLAGS-1:0]),
        .en_we(wr_en), .en_wdata(reg_wdata[NFLAGS-1:0]),
        .flags(flags), .en(en), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            ADDR_DATA:   reg_rdata = {8'h00, rx_head};
            ADDR_STAT:   reg_rdata = REG_W'(flags);
            ADDR_IRQEN:  reg_rdata = REG_W'(en);
            ADDR_BUFCTL: reg_rdata = {2'b00, rx_thm1, 2'b00, tx_thm1};
            ADDR_COUNT:  reg_rdata = count_q;
            ADDR_LEVEL:  reg_rdata = {8'(rx_lvl), 8'(tx_lvl)};
            ADDR_DEPTH:  reg_rdata = REG_W'(FIFO_AW - 3);
            ADDR_RSVD:   reg_rdata = '0;
        endcase
    end

    // R9: no interrupt while nothing is enabled
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

endmodule

// File: tb/i2c_fifo_irq_unit_test.sv
module i2c_fifo_irq_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int FIFO_AW    = 4;
    localparam int DEPTH      = 1 << FIFO_AW;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_we = 0, reg_re = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic        eng_tx_take = 0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_empty;
    logic        eng_rx_put = 0;
    logic [7:0]  eng_rx_byte = 0;
    logic        eng_rx_full;

    i2c_fifo_irq_unit #(.FIFO_AW(FIFO_AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .eng_tx_take(eng_tx_take), .eng_tx_byte(eng_tx_byte),
        .eng_tx_empty(eng_tx_empty), .eng_rx_put(eng_rx_put),
        .eng_rx_byte(eng_rx_byte), .eng_rx_full(eng_rx_full)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int m_txl = 0, m_rxl = 0, thr_t = 1, thr_r = 1;
    bit m_armed = 0;
    logic [3:0] m_en = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_cond();
        logic [3:0] c = 0;
        c[3] = (m_txl > 0) && (m_txl < thr_t) && (txq.size() < thr_t);
        c[2] = (m_txl >= thr_t) && (txq.size() < thr_t);
        c[1] = m_armed && (m_rxl == 0) && (rxq.size() > 0) && (rxq.size() < thr_r);
        c[0] = (rxq.size() >= thr_r);
        return c;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
        @(posedge clk); #1 reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_re = 1; #1 d = reg_rdata;
        @(posedge clk); #1 reg_re = 0;
    endtask

    task automatic settle(); repeat (3) @(negedge clk); endtask

    task automatic sw_push(input logic [7:0] b);
        wr(3'd0, {8'h00, b});
        if (txq.size() < DEPTH) begin
            txq.push_back(b);
            if (m_txl > 0) m_txl--;
        end
    endtask

    task automatic sw_pop(input string req);
        logic [15:0] d;
        logic [7:0] e;
        e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
        rd(3'd0, d);
        chk(req, d, {8'h00, e});
    endtask

    task automatic eng_take(input string req);
        @(negedge clk);
        eng_tx_take = 1;
        #1;
        if (txq.size() > 0) chk(req, eng_tx_byte, txq.pop_front());
        else chk(req, eng_tx_empty, 1);
        @(posedge clk); #1 eng_tx_take = 0;
    endtask

    task automatic eng_put(input logic [7:0] b);
        @(negedge clk); eng_rx_put = 1; eng_rx_byte = b;
        @(posedge clk); #1 eng_rx_put = 0;
        if (rxq.size() < DEPTH) begin
            rxq.push_back(b);
            if (m_rxl > 0) m_rxl--;
        end
    endtask

    task automatic load_count(input int n);
        wr(3'd4, 16'(n)); m_txl = n; m_rxl = n; m_armed = 1;
    endtask

    function automatic logic [15:0] ctl_word();
        return 16'(((thr_r - 1) << 8) | (thr_t - 1));
    endfunction

    task automatic set_thr(input int t, input int r);
        thr_t = t; thr_r = r; wr(3'd3, ctl_word());
    endtask

    task automatic flush(input bit ft, input bit fr);
        wr(3'd3, ctl_word() | (ft ? 16'h0040 : 16'h0) | (fr ? 16'h4000 : 16'h0));
        if (ft) txq.delete();
        if (fr) rxq.delete();
    endtask

    task automatic set_en(input logic [3:0] e);
        wr(3'd2, {12'h0, e}); m_en = e;
    endtask

    task automatic check_status(input string req);
        logic [15:0] d;
        logic [3:0] c;
        settle();
        wr(3'd1, 16'h000F);
        settle();
        c = model_cond();
        rd(3'd1, d);
        chk(req, d, {12'h0, c});
        chk("R9 irq", irq, |(c & m_en));
        rd(3'd5, d);
        chk("R11 levels", d, {8'(rxq.size()), 8'(txq.size())});
    endtask

    task automatic raw_rx(input string req, input logic [1:0] exp);
        logic [15:0] d;
        settle();
        rd(3'd1, d);
        chk(req, d[1:0], exp);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] d;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(3'd1, d); chk("R1 status", d, 0);
        rd(3'd2, d); chk("R1 enable", d, 0);
        rd(3'd3, d); chk("R1 control", d, 0);
        rd(3'd4, d); chk("R1 count", d, 0);
        rd(3'd5, d); chk("R1 levels", d, 0);
        chk("R1 irq", irq, 0);
        // R12 depth code
        rd(3'd6, d); chk("R12 depth code", d, 16'(FIFO_AW - 3));

        // R2 threshold encoding
        set_thr(5, 3);
        rd(3'd3, d); chk("R2 control readback", d, 16'h0204);

        // R5 transmit ready, R13 count load
        set_thr(4, 4);
        load_count(10);
        rd(3'd4, d); chk("R13 count readback", d, 16'd10);
        check_status("R5 tx ready");
        rd(3'd1, d); chk("R5 tx ready bit", d, 16'h0004);
        for (int i = 1; i <= 7; i++) sw_push(8'(i));
        check_status("R6 tail above threshold");
        for (int i = 0; i < 4; i++) eng_take("R11 tx order");
        check_status("R6 tx drain");
        rd(3'd1, d); chk("R6 tx drain bit", d, 16'h0008);

        // R9 interrupt masking
        set_en(4'h8);
        check_status("R9 enabled drain");
        chk("R9 irq high", irq, 1);
        set_en(4'h4);
        check_status("R9 masked drain");
        chk("R9 irq low", irq, 0);

        // R3 R4 R7 R8 receive sequence
        flush(1, 1);
        load_count(5);
        wr(3'd1, 16'h000F);
        eng_put(8'h11); eng_put(8'h22); eng_put(8'h33); eng_put(8'h44);
        raw_rx("R3 rx ready", 2'b01);
        sw_pop("R11 rx order"); sw_pop("R11 rx order");
        raw_rx("R8 sticky ready", 2'b01);
        eng_put(8'h55);
        raw_rx("R7 drain replaces ready", 2'b10);
        wr(3'd1, 16'h0002);
        raw_rx("R8 clear loses to live condition", 2'b10);
        sw_pop("R4 rx drain data"); sw_pop("R4 rx drain data"); sw_pop("R4 rx drain data");
        raw_rx("R8 sticky drain", 2'b10);
        wr(3'd1, 16'h0002);
        raw_rx("R8 write-one clear", 2'b00);

        // R10 flush
        sw_push(8'hA1); sw_push(8'hA2); eng_put(8'hB1); eng_put(8'hB2);
        rd(3'd5, d); chk("R11 levels before flush", d, 16'h0202);
        flush(1, 0);
        rd(3'd5, d); chk("R10 tx flush only", d, 16'h0200);
        flush(0, 1);
        rd(3'd5, d); chk("R10 rx flush", d, 16'h0000);
        rd(3'd3, d); chk("R10 flush bits read 0", d, ctl_word());

        // R11 full and empty boundaries
        for (int i = 0; i < DEPTH + 1; i++) sw_push(8'(8'h40 + i));
        rd(3'd5, d); chk("R11 full level", d, 16'(DEPTH));
        for (int i = 0; i < DEPTH; i++) eng_take("R11 tx order full");
        chk("R11 tx empty", eng_tx_empty, 1);
        sw_pop("R11 empty pop returns 0");
        check_status("R13 after boundaries");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 7);
            case (op)
                0: sw_push(8'($urandom));
                1: eng_take("R11 random tx");
                2: eng_put(8'($urandom));
                3: sw_pop("R11 random rx");
                4: load_count($urandom_range(0, 20));
                5: set_thr($urandom_range(1, 8), $urandom_range(1, 8));
                6: flush(1'($urandom), 1'($urandom));
                default: set_en(4'($urandom));
            endcase
            check_status("R3 R4 R5 R6 R13 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule